// File: doc/BRIEF.md
# Timed Interrupt Hold-Off Counter

This block keeps interrupt requests from reaching the core for a programmed number of instruction cycles. When a hold-off command is issued with a count operand N, the block masks the request line during the command's own instruction cycle. It then keeps the line masked for N further instruction cycles. Instruction cycles are marked by a cycle-enable input, so stalled clocks do not use up the window.

A second command reloads the countdown with its own operand. This holds whether it arrives while a window is running, on the last masked cycle, or on the very cycle where the count has just run out. In every case the masking carries on with no unmasked cycle in between. Outside a window, the raw request passes straight through to the output.

Top module: `irq_holdoff`

## Requirements
- R1: On an instruction cycle where a command is accepted (`cmd_vld` and `cyc_en` both high), `busy` is high and `irq_out` is low in that same cycle.
- R2: A command with operand N keeps `busy` high for exactly N+1 instruction cycles: the command cycle plus N more. `busy` is low on the next instruction cycle after that. This holds for the largest operand, 2^CNT_W-1.
- R3: A command with operand 0 masks only its own command cycle.
- R4: A command accepted while a window is still running restarts the window from that command cycle. The window then lasts the new operand plus one cycle, whether that is longer or shorter than what remained.
- R5: A command on the first instruction cycle after a window has run out is masked in that cycle. Its window follows with no unmasked cycle between the two windows.
- R6: Cycles with `cyc_en` low neither shorten nor end a window, and `busy` keeps its value through them. A `cmd_vld` pulse while `cyc_en` is low is ignored.
- R7: `irq_out` equals `irq_raw` whenever `busy` is low. A request held through a window appears on `irq_out` in the first cycle with `busy` low.
- R8: While `rst_n` is low and after it is released, `busy` is low and `irq_out` follows `irq_raw`.
- R9: After a window ends with no retrigger, a later command masks interrupts again with the normal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | High on clocks that complete an instruction cycle |
| cmd_vld | input | 1 | Hold-off command strobe |
| cmd_cnt | input | CNT_W | Command operand N |
| irq_raw | input | 1 | Unmasked interrupt request |
| irq_out | output | 1 | Interrupt request after masking |
| busy | output | 1 | High while interrupts are held off |

## Verification
The hardest case to reach is a command that lands exactly on the first instruction cycle after the countdown has expired. A command one cycle earlier or later checks something else. The bench issues a command and then counts out exactly N+1 driven instruction cycles before the second command, and it does the same with stall cycles mixed into the first window. A per-cycle scoreboard then confirms that `busy` never drops between the two windows and that a held request only gets through after the second window.

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             cmd_vld,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic             irq_raw,
  output logic             irq_out,
  output logic             busy
);

  logic [CNT_W-1:0] rem;
  logic             armed;
  logic             fire;

  assign fire    = cmd_vld & cyc_en;
  assign busy    = armed | fire;
  assign irq_out = irq_raw & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      armed <= 1'b0;
    end else if (fire) begin
      rem   <= cmd_cnt;
      armed <= (cmd_cnt != '0);
    end else if (armed && cyc_en) begin
      rem   <= rem - 1'b1;
      armed <= (rem != {{(CNT_W-1){1'b0}}, 1'b1});
    end
  end

  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rem != '0); // R2
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rem == $past(cmd_cnt)) && (armed == ($past(cmd_cnt) != '0))); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cyc_en && !cmd_vld && rem > 1) |=> armed && rem == $past(rem) - 1'b1); // R2
  AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cyc_en && !cmd_vld && rem == 1) |=> !armed); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en) |=> $stable(rem) && $stable(armed)); // R6
  AST_RETRIG_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_cnt != '0) |=> busy && !irq_out); // R5
  AST_NO_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !irq_out); // R1

endmodule

// File: tb/irq_holdoff_test.sv
`timescale 1ns/1ps
module irq_holdoff_test;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0;
  logic cmd_vld = 1'b0;
  logic [W-1:0] cmd_cnt = '0;
  logic irq_raw = 1'b0;
  logic irq_out, busy;

  irq_holdoff #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cmd_vld(cmd_vld),
    .cmd_cnt(cmd_cnt), .irq_raw(irq_raw), .irq_out(irq_out), .busy(busy)
  );

  always #2.5 clk = ~clk;

  typedef struct { bit busy; bit irq; int req; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  int ml = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input int req, input bit ab, input bit ai,
                       input bit eb, input bit ei);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d busy=%0b irq_out=%0b expected busy=%0b irq_out=%0b at %0t",
               req, ab, ai, eb, ei, $time);
    end
  endtask

  // one cycle of stimulus; expected result from the window rules
  task automatic step(input bit ce, input bit cv, input int n, input bit ir, input int req);
    exp_t e;
    @(negedge clk);
    cyc_en = ce; cmd_vld = cv; cmd_cnt = n[W-1:0]; irq_raw = ir;
    if (ce && cv) ml = n + 1;
    e.busy = (ml > 0);
    e.irq  = ir && !e.busy;
    e.req  = req;
    q.push_back(e);
    if (ce && ml > 0) ml--;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(busy == e.busy && irq_out == e.irq, e.req, busy, irq_out, e.busy, e.irq);
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // R8: reset state
    irq_raw = 1'b1;
    #7;
    check(busy == 1'b0 && irq_out == 1'b1, 8, busy, irq_out, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 0, 1, 8);
    step(1, 0, 0, 0, 8);

    // R1 R2 R7: single window N=3 with held request
    step(1, 1, 3, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 2);
    step(1, 0, 0, 1, 7);
    step(1, 0, 0, 0, 7);

    // R3: operand 0
    step(1, 1, 0, 1, 3);
    step(1, 0, 0, 1, 3);

    // R4: retrigger longer and shorter
    step(1, 1, 5, 0, 4);
    step(1, 0, 0, 1, 4);
    step(1, 1, 6, 1, 4);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 4);
    step(1, 1, 1, 1, 4);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 4);

    // R5: retrigger on first cycle after expiry
    step(1, 1, 2, 1, 5);
    step(1, 0, 0, 1, 5);
    step(1, 0, 0, 1, 5);
    step(1, 1, 2, 1, 5);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 5);
    // R5 with stalls inside first window
    step(1, 1, 2, 1, 5);
    step(0, 0, 0, 1, 6);
    step(1, 0, 0, 1, 5);
    step(0, 0, 0, 1, 6);
    step(1, 0, 0, 1, 5);
    step(1, 1, 1, 1, 5);
    step(1, 0, 0, 1, 5);
    step(1, 0, 0, 1, 5);

    // R6: stalls and ignored command
    step(0, 1, 9, 1, 6);
    step(1, 0, 0, 1, 6);
    step(1, 1, 1, 1, 6);
    step(0, 0, 0, 1, 6);
    step(0, 1, 7, 1, 6);
    step(0, 0, 0, 1, 6);
    step(1, 0, 0, 1, 6);
    step(1, 0, 0, 1, 6);
    step(0, 0, 0, 1, 6);

    // R9: later command after idle
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 9);
    step(1, 1, 4, 0, 9);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 9);
    step(1, 0, 0, 1, 9);

    // R2: largest operand
    step(1, 1, (1 << W) - 1, 1, 2);
    for (int i = 0; i < (1 << W) - 1; i++) step(1, 0, 0, 1, 2);
    step(1, 0, 0, 1, 2);
    step(1, 0, 0, 0, 2);

    @(negedge clk); @(negedge clk); #3;
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule